// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block is the digital side of a two-channel parallel-input digital-to-analog converter. Each channel holds two registers: a staging register that captures the parallel data bus and an output register whose code drives the converter. A two-bit address chooses which channels a command affects: channel A, channel B, both, or none. Two strobe levels pick the operation: an active-low write and an active-high load. The operations are capture into staging, copy staging to output, pass the bus straight through to the output, or hold.

The strobes come from another timing domain. Each one passes through a two-flop synchronizer, so its level is acted on three clock edges after it changes. The address and data bus are not synchronized and must be held steady around a strobe change. An active-low reset clears both registers of both channels at once, without waiting for a clock. The reset value is zero scale or midscale, chosen by a select pin. For a 16-bit data width, each channel also drives a 15-wide thermometer vector decoded from the top four bits of its output code, meant for a segmented converter core.

Top module: `dual_dac_regif`

## Requirements
- R1: The address decodes as follows: `adr`=00 selects channel A, 11 selects channel B, 10 selects both channels, and 01 selects neither. With 01, no register changes in any mode.
- R2: While `rst_n` is low, both registers of both channels take zero scale (all bits 0) without waiting for a clock edge when `mid_sel`=0.
- R3: While `rst_n` is low with `mid_sel`=1, both registers of both channels take midscale (only the top bit set). This applies to the staging registers as well as the output registers.
- R4: With `wr_n`=0 and `ld`=0, the staging registers of the selected channels take `din` and the output codes do not change.
- R5: With `wr_n`=1 and `ld`=1, the output register of each selected channel copies its staging register.
- R6: With `wr_n`=0 and `ld`=1, both registers of each selected channel take `din`, so the bus value appears on the output code.
- R7: With `wr_n`=1 and `ld`=0, neither register of either channel changes.
- R8: When `wr_n` and `ld` move together as one low pulse, the low phase captures `din` into staging with the output unchanged. The return high then moves it to the output.
- R9: For DATA_W=16, bit i of `seg_a`/`seg_b` (i = 0..14) is 1 exactly when the top four bits of that channel's code, read as an unsigned number, exceed i.
- R10: The registers of a channel that the address does not select never change, in any mode.
- R11: A change of strobe levels reaches the output code on the third rising clock edge after the change, and not before.
- R12: While `rst_n` is low, strobe activity has no effect: the outputs keep the reset value throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mid_sel | input | 1 | Reset value select: 0 gives zero scale, 1 gives midscale |
| wr_n | input | 1 | Write strobe level, active low |
| ld | input | 1 | Load strobe level, active high |
| adr | input | 2 | Channel address |
| din | input | DATA_W | Parallel data bus |
| code_a | output | DATA_W | Output-register code of channel A |
| code_b | output | DATA_W | Output-register code of channel B |
| seg_a | output | 15 | Thermometer segment enables of channel A |
| seg_b | output | 15 | Thermometer segment enables of channel B |

## Verification
A corrupted staging register cannot be seen when it is written. It shows up only when a later copy command moves it to the output code, three edges after that strobe. For that reason every capture is followed by a copy before its check. A wrong output register, or a write to a channel that was not selected, shows up on the code and segment ports within the same three edges. The hold and no-channel commands are therefore checked at the ports once that latency has passed.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_XFER    = 2'd2,
        MODE_TRANSP  = 2'd3
    } mode_e;

    localparam logic [1:0] ADR_A    = 2'b00;
    localparam logic [1:0] ADR_NONE = 2'b01;
    localparam logic [1:0] ADR_BOTH = 2'b10;
    localparam logic [1:0] ADR_B    = 2'b11;

    // strobe levels to operation
    function automatic mode_e mode_of(input logic wr_n, input logic ld);
        mode_e m;
        case ({wr_n, ld})
            2'b00:   m = MODE_CAPTURE;
            2'b01:   m = MODE_TRANSP;
            2'b11:   m = MODE_XFER;
            default: m = MODE_HOLD;
        endcase
        return m;
    endfunction

    // bit 0 selects channel A, bit 1 selects channel B
    function automatic logic [1:0] chan_sel(input logic [1:0] adr);
        logic [1:0] s;
        case (adr)
            ADR_A:    s = 2'b01;
            ADR_B:    s = 2'b10;
            ADR_BOTH: s = 2'b11;
            default:  s = 2'b00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: RST_VAL, s2: RST_VAL};
        else        st_q <= st_d;
    end

    assign q = st_q.s2;

endmodule

// File: rtl/dacif_chan.sv
module dacif_chan
    import dacif_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rst_val,
    input  logic              sel,
    input  mode_e             mode,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] code
);
    typedef struct packed {
        logic [DATA_W-1:0] stage;
        logic [DATA_W-1:0] outr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (sel) begin
            case (mode)
                MODE_CAPTURE: r_d.stage = data;
                MODE_XFER:    r_d.outr  = r_q.stage;
                MODE_TRANSP: begin
                    r_d.stage = data;
                    r_d.outr  = data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{stage: rst_val, outr: rst_val};
        else        r_q <= r_d;
    end

    assign code = r_q.outr;

    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && mode == MODE_CAPTURE) |=>
            (r_q.outr == $past(r_q.outr) && r_q.stage == $past(data)));

    assert_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && mode == MODE_XFER) |=> (r_q.outr == $past(r_q.stage)));

    assert_transp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && mode == MODE_TRANSP) |=> (code == $past(data)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(r_q));

    assert_unsel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel) |=> $stable(r_q));

endmodule

// File: rtl/dacif_therm.sv
module dacif_therm #(
    parameter int SEG_BITS = 4,
    parameter int SEGS     = (1 << SEG_BITS) - 1
) (
    input  logic [SEG_BITS-1:0] msb,
    output logic [SEGS-1:0]     seg
);
    for (genvar i = 0; i < SEGS; i++) begin : g_seg
        assign seg[i] = (msb > SEG_BITS'(i));
    end

    always_comb begin
        if (!$isunknown(msb)) begin
            assert_therm_count_R9: assert ($countones(seg) == int'(msb));
            assert_therm_shape_R9: assert ((seg & (seg + 1'b1)) == '0);
        end
    end

endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
    import dacif_pkg::*;
#(
    parameter int   DATA_W   = 16,
    parameter int   SEG_BITS = 4,
    localparam int  SEGS     = (1 << SEG_BITS) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mid_sel,
    input  logic              wr_n,
    input  logic              ld,
    input  logic [1:0]        adr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic [SEGS-1:0]   seg_a,
    output logic [SEGS-1:0]   seg_b
);
    localparam int NCH = 2;

    logic              rst_int_n;
    logic [1:0]        strb_s;
    logic [DATA_W-1:0] rst_val;
    logic [NCH-1:0]    sel;
    mode_e             mode;
    logic [DATA_W-1:0] code_v [NCH];
    logic [SEGS-1:0]   seg_v  [NCH];

    // reset: asynchronous assertion, synchronized release
    dacif_sync #(.W(1), .RST_VAL(1'b0)) u_rst_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (1'b1),
        .q     (rst_int_n)
    );

    // strobes idle at write high, load low (hold)
    dacif_sync #(.W(2), .RST_VAL(2'b10)) u_strb_sync (
        .clk   (clk),
        .rst_n (rst_int_n),
        .d     ({wr_n, ld}),
        .q     (strb_s)
    );

    always_comb begin
        rst_val = '0;
        rst_val[DATA_W-1] = mid_sel;
        mode = mode_of(strb_s[1], strb_s[0]);
        sel  = chan_sel(adr);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dacif_chan #(.DATA_W(DATA_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_int_n),
            .rst_val (rst_val),
            .sel     (sel[c]),
            .mode    (mode),
            .data    (din),
            .code    (code_v[c])
        );
        if (DATA_W == 16) begin : g_seg
            dacif_therm #(.SEG_BITS(SEG_BITS), .SEGS(SEGS)) u_therm (
                .msb (code_v[c][DATA_W-1 -: SEG_BITS]),
                .seg (seg_v[c])
            );
        end else begin : g_noseg
            assign seg_v[c] = '0;
        end
    end

    assign code_a = code_v[0];
    assign code_b = code_v[1];
    assign seg_a  = seg_v[0];
    assign seg_b  = seg_v[1];

    assert_addr_none_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
        (adr == ADR_NONE) |=> ($stable(code_a) && $stable(code_b)));

endmodule

// File: tb/dual_dac_regif_tb.sv
module dual_dac_regif_tb;
    localparam int DW   = 16;
    localparam int SEGS = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mid_sel = 1'b0;
    logic          wr_n = 1'b1;
    logic          ld = 1'b0;
    logic [1:0]    adr = 2'b01;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] code_a, code_b;
    logic [SEGS-1:0] seg_a, seg_b;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;

    logic [DW-1:0] stage_m [2];
    logic [DW-1:0] out_m   [2];

    always #2.5 clk = ~clk;

    dual_dac_regif u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .mid_sel (mid_sel),
        .wr_n    (wr_n),
        .ld      (ld),
        .adr     (adr),
        .din     (din),
        .code_a  (code_a),
        .code_b  (code_b),
        .seg_a   (seg_a),
        .seg_b   (seg_b)
    );

    function automatic logic [SEGS-1:0] therm(input logic [DW-1:0] c);
        logic [SEGS-1:0] r;
        for (int i = 0; i < SEGS; i++) r[i] = (int'(c[DW-1 -: 4]) > i);
        return r;
    endfunction

    function automatic void chk(input string tag, input logic [31:0] act,
                                input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    // model: 00 -> A, 11 -> B, 10 -> both, 01 -> none
    function automatic void model_apply(input logic w, input logic l,
                                        input logic [1:0] a, input logic [DW-1:0] d);
        for (int c = 0; c < 2; c++) begin
            bit s = (c == 0) ? (a == 2'b00 || a == 2'b10)
                             : (a == 2'b11 || a == 2'b10);
            if (s) begin
                if (!w && !l) stage_m[c] = d;
                else if (!w && l) begin stage_m[c] = d; out_m[c] = d; end
                else if (w && l) out_m[c] = stage_m[c];
            end
        end
    endfunction

    function automatic void model_reset(input logic m);
        for (int c = 0; c < 2; c++) begin
            stage_m[c] = m ? 16'h8000 : 16'h0000;
            out_m[c]   = stage_m[c];
        end
    endfunction

    task automatic step(input logic w, input logic l, input logic [1:0] a,
                        input logic [DW-1:0] d, input bit idle_first, input string tag);
        exp_t e;
        if (idle_first) begin
            wr_n = 1'b1; ld = 1'b0;
            repeat (4) @(negedge clk);
            adr = a; din = d;
            @(negedge clk);
        end
        wr_n = w; ld = l;
        model_apply(w, l, a, d);
        e.a = out_m[0]; e.b = out_m[1]; e.tag = tag;
        exp_q.push_back(e);
        repeat (4) @(negedge clk);
        ->chk_ev;
        #1;
    endtask

    // monitor: compare ports against scoreboard entries
    initial begin
        forever begin
            exp_t e;
            @(chk_ev);
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", 0, 1);
            end else begin
                e = exp_q.pop_front();
                chk({e.tag, " code_a"}, 32'(code_a), 32'(e.a));
                chk({e.tag, " code_b"}, 32'(code_b), 32'(e.b));
                chk({e.tag, " seg_a R9"}, 32'(seg_a), 32'(therm(e.a)));
                chk({e.tag, " seg_b R9"}, 32'(seg_b), 32'(therm(e.b)));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset(1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 reset zero code_a", 32'(code_a), 0);
        chk("R2 reset zero code_b", 32'(code_b), 0);

        step(1'b0, 1'b0, 2'b00, 16'h1234, 1'b1, "R4 capture A");
        step(1'b1, 1'b1, 2'b00, 16'h0000, 1'b1, "R5 xfer A");
        step(1'b0, 1'b0, 2'b11, 16'hF00D, 1'b1, "R4 capture B");
        step(1'b1, 1'b1, 2'b00, 16'h0000, 1'b1, "R10 xfer A leaves B");
        step(1'b1, 1'b1, 2'b11, 16'h0000, 1'b1, "R5 xfer B");
        step(1'b0, 1'b0, 2'b01, 16'h5555, 1'b1, "R1 capture none");
        step(1'b1, 1'b1, 2'b10, 16'h0000, 1'b1, "R1 xfer both after none");
        step(1'b0, 1'b1, 2'b01, 16'h7777, 1'b1, "R1 transparent none");
        step(1'b0, 1'b1, 2'b10, 16'hABCD, 1'b1, "R6 transparent both");
        step(1'b0, 1'b1, 2'b00, 16'h0FFF, 1'b1, "R6 R10 transparent A");
        step(1'b1, 1'b0, 2'b10, 16'h1111, 1'b1, "R7 hold");
        step(1'b1, 1'b1, 2'b11, 16'h1111, 1'b1, "R7 xfer B after hold");
        step(1'b0, 1'b0, 2'b11, 16'h9C00, 1'b1, "R8 pulse low");
        step(1'b1, 1'b1, 2'b11, 16'h9C00, 1'b0, "R8 pulse high");
        step(1'b0, 1'b1, 2'b10, 16'hFFFF, 1'b1, "R9 full scale both");

        // R11: latency of three rising edges
        wr_n = 1'b1; ld = 1'b0;
        repeat (4) @(negedge clk);
        adr = 2'b00; din = 16'h4321;
        @(negedge clk);
        wr_n = 1'b0; ld = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 unchanged after two edges", 32'(code_a), 32'(out_m[0]));
        @(negedge clk);
        model_apply(1'b0, 1'b1, 2'b00, 16'h4321);
        chk("R11 updated on third edge", 32'(code_a), 32'h4321);
        wr_n = 1'b1; ld = 1'b0;
        repeat (4) @(negedge clk);

        // R3 / R12: midscale reset, asynchronous, strobes ignored
        mid_sel = 1'b1;
        #1 rst_n = 1'b0;
        #1;
        model_reset(1'b1);
        chk("R3 async midscale code_a", 32'(code_a), 32'h8000);
        chk("R3 async midscale code_b", 32'(code_b), 32'h8000);
        adr = 2'b10; din = 16'h2468;
        wr_n = 1'b0; ld = 1'b1;
        repeat (6) @(negedge clk);
        wr_n = 1'b1; ld = 1'b1;
        repeat (6) @(negedge clk);
        chk("R12 strobes ignored code_a", 32'(code_a), 32'h8000);
        chk("R12 strobes ignored code_b", 32'(code_b), 32'h8000);
        wr_n = 1'b1; ld = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        step(1'b1, 1'b1, 2'b10, 16'h0000, 1'b1, "R3 staging midscale");

        // R2: zero-scale reset again, asynchronous
        mid_sel = 1'b0;
        #1 rst_n = 1'b0;
        #1;
        model_reset(1'b0);
        chk("R2 async zero code_a", 32'(code_a), 0);
        chk("R2 async zero seg_b", 32'(seg_b), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        step(1'b1, 1'b1, 2'b10, 16'h0000, 1'b1, "R2 staging zero");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule